// File: doc/BRIEF.md
# Sampled Current-Command Switch Controller

This block is the inner current loop of a boost power-factor-correction stage. A switching tick arrives once per switching period. On each tick the block takes the sampled rectified input voltage and the sampled inductor current. It forms a current command by multiplying the input voltage by a gain. It then fixes the transistor gate state for the whole of the following period: the gate is on when the inductor current is below the command and off otherwise. Between ticks the gate, and the command that produced it, do not change.

An outer voltage loop supplies the gain through a load strobe. A gain loaded at any time is held in a staging register. It becomes active only at the next tick, and that tick's decision already uses it. This lets the outer loop update the gain once per line half-cycle or as often as every switching period, and a period is never split. A counter reports how many ticks have passed since the last gain change. Its range covers a full line half-cycle, which is about 830 switching periods.

Top module: `ccmd_sw_ctrl`

## Requirements
- R1: `gate_o` and `cmd_o` change only in the cycle that follows a cycle with `tick_i` high. In every other cycle they keep their value, whatever the samples and the gain input do.
- R2: On a tick, `cmd_o` takes the current command and `gate_o` becomes 1 when `iind_i` is strictly below that command, and 0 when it is equal or above.
- R3: The command is floor(gain × vin / 2^14). The gain is unsigned with 14 fraction bits (16384 means 1.0). `vin_i` and `iind_i` are unsigned 12-bit samples on the same scale.
- R4: When floor(gain × vin / 2^14) exceeds 4095, the command saturates to 4095 and does not wrap.
- R5: A gain loaded with `gain_ld_i` in a cycle without a tick is used by the command computed at the next tick, and by every tick after that until another gain is taken up.
- R6: A gain loaded between ticks has no effect on `gate_o` or `cmd_o` before the next tick. When several loads fall in one period, the last one wins.
- R7: A gain loaded in the same cycle as a tick is not used at that tick. The old gain decides that tick, and the new gain takes effect at the following tick.
- R8: `per_cnt_o` goes to 0 on a tick that takes up a new gain. On any other tick it goes up by one, saturating at 1023, so it can count past 830. Between ticks it holds.
- R9: After reset `gate_o`, `cmd_o` and `per_cnt_o` are 0 and the active gain is 0. A tick before any gain load therefore gives command 0 and gate off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | One-cycle strobe marking the start of a switching period |
| vin_i | input | 12 | Sampled rectified input voltage |
| iind_i | input | 12 | Sampled inductor current |
| gain_i | input | 16 | Gain from the outer loop, unsigned with 14 fraction bits |
| gain_ld_i | input | 1 | Load strobe for `gain_i` |
| gate_o | output | 1 | Transistor gate for the current period (1 = on) |
| cmd_o | output | 12 | Current command used for the current period's decision |
| per_cnt_o | output | 10 | Ticks since the last gain take-up, saturating |

## Verification
The compare is driven with the inductor current one below, equal to and one above the command. This separates a strict compare from a non-strict one. Gains of 1.0, 1.5, 2.0 and fractional non-powers of two, applied to small and large voltages, separate correct truncation from rounding. Commands of exactly 4094 and 4096 separate saturation from wrapping. Gain loads placed mid-period, repeated within one period and coinciding with a tick show whether the take-up happens at the right boundary and with the right value. A run of more than a thousand ticks without a load exercises the counter's saturation.

// File: rtl/ccmd_pkg.sv
package ccmd_pkg;

   // Default sizing shared by the controller and its parts
   localparam int unsigned CCMD_VW_DEF    = 12;
   localparam int unsigned CCMD_IW_DEF    = 12;
   localparam int unsigned CCMD_GW_DEF    = 16;
   localparam int unsigned CCMD_FRAC_DEF  = 14;
   localparam int unsigned CCMD_CNTW_DEF  = 10;
   localparam int unsigned CCMD_LINE_DEF  = 830;

   typedef enum logic {
      SW_OFF = 1'b0,
      SW_ON  = 1'b1
   } sw_state_e;

endpackage

// File: rtl/ccmd_gain_stage.sv
module ccmd_gain_stage #(
   parameter int unsigned GW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          tick,
   input  logic [GW-1:0] gain_in,
   input  logic          gain_ld,
   output logic [GW-1:0] gain_eff,
   output logic          commit
);

   logic [GW-1:0] act_q;
   logic [GW-1:0] pend_q;
   logic          pend_v_q;

   // The gain that governs a tick in this cycle: a staged one overrides
   assign gain_eff = pend_v_q ? pend_q : act_q;
   assign commit   = tick & pend_v_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         act_q    <= '0;
         pend_q   <= '0;
         pend_v_q <= 1'b0;
      end else begin
         if (commit) begin
            act_q <= pend_q;
         end
         if (gain_ld) begin
            pend_q   <= gain_in;
            pend_v_q <= 1'b1;
         end else if (tick) begin
            pend_v_q <= 1'b0;
         end
      end
   end

   // Active gain only moves on a switching boundary (R5, R6)
   p_act_boundary_r6 : assert property (@(posedge clk) disable iff (!rst_n)
      !tick |=> $stable(act_q));

   // A load in a tick cycle stays staged for the following tick (R7)
   p_same_cycle_load_r7 : assert property (@(posedge clk) disable iff (!rst_n)
      (tick && gain_ld) |=> (pend_v_q && pend_q == $past(gain_in)));

endmodule

// File: rtl/ccmd_cmd_calc.sv
module ccmd_cmd_calc #(
   parameter int unsigned VW     = 12,
   parameter int unsigned GW     = 16,
   parameter int unsigned IW     = 12,
   parameter int unsigned FRAC   = 14,
   parameter bit          SAT_EN = 1'b1
) (
   input  logic [GW-1:0] gain,
   input  logic [VW-1:0] vin,
   output logic [IW-1:0] cmd
);

   localparam int unsigned PW = GW + VW;
   localparam int unsigned SW = PW - FRAC;

   logic [PW-1:0] prod;
   logic [SW-1:0] shf;

   always_comb begin
      prod = {{VW{1'b0}}, gain} * {{GW{1'b0}}, vin};
   end

   assign shf = prod[PW-1:FRAC];

   generate
      if (SW > IW) begin : g_wide
         if (SAT_EN) begin : g_sat
            assign cmd = (|shf[SW-1:IW]) ? {IW{1'b1}} : shf[IW-1:0];
         end else begin : g_wrap
            assign cmd = shf[IW-1:0];
         end
      end else begin : g_narrow
         assign cmd = IW'(shf);
      end
   endgenerate

endmodule

// File: rtl/ccmd_period_core.sv
module ccmd_period_core #(
   parameter int unsigned IW    = 12,
   parameter int unsigned CNT_W = 10
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic             commit,
   input  logic [IW-1:0]    cmd_nxt,
   input  logic [IW-1:0]    iind,
   output logic             gate,
   output logic [IW-1:0]    cmd_q,
   output logic [CNT_W-1:0] cnt_q
);

   import ccmd_pkg::*;

   localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

   sw_state_e sw_q;
   sw_state_e sw_d;

   always_comb begin
      sw_d = (iind < cmd_nxt) ? SW_ON : SW_OFF;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sw_q  <= SW_OFF;
         cmd_q <= '0;
         cnt_q <= '0;
      end else if (tick) begin
         sw_q  <= sw_d;
         cmd_q <= cmd_nxt;
         if (commit) begin
            cnt_q <= '0;
         end else if (cnt_q != CNT_MAX) begin
            cnt_q <= cnt_q + 1'b1;
         end
      end
   end

   assign gate = (sw_q == SW_ON);

   // Gate and command hold through the period (R1)
   p_gate_hold_r1 : assert property (@(posedge clk) disable iff (!rst_n)
      !tick |=> ($stable(gate) && $stable(cmd_q)));

   // A zero command can never turn the switch on (R2)
   p_zero_cmd_off_r2 : assert property (@(posedge clk) disable iff (!rst_n)
      (tick && cmd_nxt == '0) |=> !gate);

   // Counter restarts on a gain take-up (R8)
   p_cnt_clear_r8 : assert property (@(posedge clk) disable iff (!rst_n)
      (tick && commit) |=> (cnt_q == '0));

   // Counter never wraps from full scale (R8)
   p_cnt_sat_r8 : assert property (@(posedge clk) disable iff (!rst_n)
      (tick && !commit && cnt_q == CNT_MAX) |=> (cnt_q == CNT_MAX));

   // Counter holds between ticks (R8)
   p_cnt_hold_r8 : assert property (@(posedge clk) disable iff (!rst_n)
      !tick |=> $stable(cnt_q));

endmodule

// File: rtl/ccmd_sw_ctrl.sv
module ccmd_sw_ctrl #(
   parameter int unsigned VW         = ccmd_pkg::CCMD_VW_DEF,
   parameter int unsigned IW         = ccmd_pkg::CCMD_IW_DEF,
   parameter int unsigned GW         = ccmd_pkg::CCMD_GW_DEF,
   parameter int unsigned FRAC       = ccmd_pkg::CCMD_FRAC_DEF,
   parameter int unsigned CNT_W      = ccmd_pkg::CCMD_CNTW_DEF,
   parameter int unsigned LINE_TICKS = ccmd_pkg::CCMD_LINE_DEF,
   parameter bit          SAT_EN     = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick_i,
   input  logic [VW-1:0]    vin_i,
   input  logic [IW-1:0]    iind_i,
   input  logic [GW-1:0]    gain_i,
   input  logic             gain_ld_i,
   output logic             gate_o,
   output logic [IW-1:0]    cmd_o,
   output logic [CNT_W-1:0] per_cnt_o
);

   localparam longint unsigned CNT_CAP = (64'd1 << CNT_W) - 64'd1;

   // Elaboration-time parameter checks
   generate
      if (FRAC >= GW + VW) begin : g_bad_frac
         $fatal(1, "FRAC must be below the product width");
      end
      if (CNT_W < 1 || CNT_W > 32) begin : g_bad_cntw
         $fatal(1, "CNT_W out of range");
      end
      if (CNT_CAP < LINE_TICKS) begin : g_bad_cnt
         $fatal(1, "period counter cannot span a line half-cycle");
      end
      if (VW < 1 || IW < 1 || GW < 1) begin : g_bad_w
         $fatal(1, "widths must be positive");
      end
   endgenerate

   logic [GW-1:0] gain_eff;
   logic          commit;
   logic [IW-1:0] cmd_nxt;

   ccmd_gain_stage #(
      .GW (GW)
   ) u_gain (
      .clk      (clk),
      .rst_n    (rst_n),
      .tick     (tick_i),
      .gain_in  (gain_i),
      .gain_ld  (gain_ld_i),
      .gain_eff (gain_eff),
      .commit   (commit)
   );

   ccmd_cmd_calc #(
      .VW     (VW),
      .GW     (GW),
      .IW     (IW),
      .FRAC   (FRAC),
      .SAT_EN (SAT_EN)
   ) u_calc (
      .gain (gain_eff),
      .vin  (vin_i),
      .cmd  (cmd_nxt)
   );

   ccmd_period_core #(
      .IW    (IW),
      .CNT_W (CNT_W)
   ) u_core (
      .clk     (clk),
      .rst_n   (rst_n),
      .tick    (tick_i),
      .commit  (commit),
      .cmd_nxt (cmd_nxt),
      .iind    (iind_i),
      .gate    (gate_o),
      .cmd_q   (cmd_o),
      .cnt_q   (per_cnt_o)
   );

   // A zero input voltage yields a zero command and gate off (R3)
   p_zero_vin_r3 : assert property (@(posedge clk) disable iff (!rst_n)
      (tick_i && vin_i == '0) |=> (cmd_o == '0 && !gate_o));

   // Unity gain passes the voltage sample through unchanged (R3)
   p_unity_gain_r3 : assert property (@(posedge clk) disable iff (!rst_n)
      (tick_i && FRAC < GW && gain_eff == GW'(64'd1 << FRAC)) |=> (cmd_o == IW'($past(vin_i))));

endmodule

// File: tb/ccmd_sw_ctrl_tb_top.sv
`timescale 1ns/1ps
module ccmd_sw_ctrl_tb_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        tick_i = 1'b0;
   logic [11:0] vin_i = '0;
   logic [11:0] iind_i = '0;
   logic [15:0] gain_i = '0;
   logic        gain_ld_i = 1'b0;
   logic        gate_o;
   logic [11:0] cmd_o;
   logic [9:0]  per_cnt_o;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   // Bench model state, built from the requirements
   int m_act = 0;
   int m_pend = 0;
   bit m_pv = 1'b0;
   int m_cnt = 0;

   always #2.5 clk = ~clk;

   ccmd_sw_ctrl dut_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .tick_i    (tick_i),
      .vin_i     (vin_i),
      .iind_i    (iind_i),
      .gain_i    (gain_i),
      .gain_ld_i (gain_ld_i),
      .gate_o    (gate_o),
      .cmd_o     (cmd_o),
      .per_cnt_o (per_cnt_o)
   );

   function automatic int exp_cmd(input int g, input int v);
      longint p;
      p = (longint'(g) * longint'(v)) >>> 14;
      if (p > 4095) return 4095;
      return int'(p);
   endfunction

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // One switching tick; optional gain load in the same cycle
   task automatic do_tick(input int v, input int i, input bit ld, input int g, input string req);
      int ec;
      bit eg;
      ec = exp_cmd(m_pv ? m_pend : m_act, v);
      eg = (i < ec);
      if (m_pv) begin
         m_act = m_pend;
         m_cnt = 0;
      end else if (m_cnt < 1023) begin
         m_cnt++;
      end
      m_pv = 1'b0;
      if (ld) begin
         m_pend = g;
         m_pv = 1'b1;
      end
      vin_i = 12'(v);
      iind_i = 12'(i);
      tick_i = 1'b1;
      gain_ld_i = ld;
      gain_i = 16'(g);
      @(negedge clk);
      tick_i = 1'b0;
      gain_ld_i = 1'b0;
      chk(cmd_o == 12'(ec), {req, " cmd"}, int'(cmd_o), ec);
      chk(gate_o == eg, {req, " gate"}, int'(gate_o), int'(eg));
      chk(per_cnt_o == 10'(m_cnt), {req, " cnt"}, int'(per_cnt_o), m_cnt);
   endtask

   task automatic load_gain(input int g);
      gain_i = 16'(g);
      gain_ld_i = 1'b1;
      m_pend = g;
      m_pv = 1'b1;
      @(negedge clk);
      gain_ld_i = 1'b0;
   endtask

   // Cycles without tick: inputs move, outputs must not (R1, R6)
   task automatic idle_hold(input int n, input string req);
      logic        g0;
      logic [11:0] c0;
      logic [9:0]  n0;
      g0 = gate_o;
      c0 = cmd_o;
      n0 = per_cnt_o;
      for (int k = 0; k < n; k++) begin
         vin_i = 12'(k * 517 + 9);
         iind_i = 12'(4095 - k * 331);
         @(negedge clk);
         chk(gate_o == g0 && cmd_o == c0 && per_cnt_o == n0, req,
             int'(cmd_o), int'(c0));
      end
   endtask

   task automatic t_reset;
      chk(gate_o == 1'b0, "R9 gate", int'(gate_o), 0);
      chk(cmd_o == '0, "R9 cmd", int'(cmd_o), 0);
      chk(per_cnt_o == '0, "R9 cnt", int'(per_cnt_o), 0);
      do_tick(3000, 0, 1'b0, 0, "R9 tick before load");
   endtask

   task automatic t_compare;
      load_gain(16384);
      do_tick(1000, 999, 1'b0, 0, "R5 R2 below");
      do_tick(1000, 1000, 1'b0, 0, "R2 equal");
      do_tick(1000, 1001, 1'b0, 0, "R2 above");
      do_tick(1000, 999, 1'b0, 0, "R2 below again");
   endtask

   task automatic t_hold;
      idle_hold(7, "R1 hold between ticks");
   endtask

   task automatic t_midload;
      load_gain(8192);
      idle_hold(3, "R6 no effect before tick");
      load_gain(24576);
      idle_hold(2, "R6 no effect before tick");
      do_tick(1000, 1499, 1'b0, 0, "R6 last load wins");
      do_tick(2000, 3001, 1'b0, 0, "R5 gain persists");
   endtask

   task automatic t_arith;
      load_gain(16385);
      do_tick(3, 0, 1'b0, 0, "R3 truncation small");
      load_gain(5461);
      do_tick(3000, 998, 1'b0, 0, "R3 truncation frac");
      load_gain(32768);
      do_tick(2047, 4093, 1'b0, 0, "R4 just below sat");
      do_tick(2048, 4094, 1'b0, 0, "R4 sat boundary");
      load_gain(65535);
      do_tick(4095, 4095, 1'b0, 0, "R4 full scale sat");
   endtask

   task automatic t_same_cycle;
      load_gain(16384);
      do_tick(800, 0, 1'b0, 0, "R7 setup");
      do_tick(800, 799, 1'b1, 8192, "R7 old gain at load tick");
      do_tick(800, 399, 1'b0, 0, "R7 new gain next tick");
   endtask

   task automatic t_counter;
      for (int k = 0; k < 1030; k++) begin
         do_tick(100, 50, 1'b0, 0, "R8 count run");
      end
      chk(per_cnt_o == 10'd1023, "R8 saturated", int'(per_cnt_o), 1023);
      load_gain(16384);
      do_tick(100, 50, 1'b0, 0, "R8 clear on take-up");
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_compare();
      t_hold();
      t_midload();
      t_arith();
      t_same_cycle();
      t_counter();
      if (!done) begin
         done = 1'b1;
         $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      #(5.0 * 200000);
      if (!done) begin
         done = 1'b1;
         checks++;
         failures++;
         $display("FAIL watchdog actual=timeout expected=completion");
         $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

endmodule